// File: doc/BRIEF.md
# FIFO Channel Descriptor Setup Sequencer

This block sets up one DMA channel whose FIFO lives in on-chip SRAM. A single start pulse captures the channel's geometry: the command-block base, the control-area base, the FIFO start and size, a requested line length in bytes, the DMA program start address and the base of the channel's pointer/count register group. The block then works out how many line buffers fit in the FIFO and issues the required 32-bit writes on a simple write bus, one at a time, each held until it is acknowledged.

The writes come in a fixed order. The descriptor table comes first, then the sixteen words of the command block in rising offset order, and last the four pointer and count registers. A one-cycle done pulse closes the sequence and the line count is reported alongside it. A geometry in which not even one line fits is refused: the block writes nothing and reports an error with the done pulse.

Top module: `chan_desc_seq`

## Requirements
- R1: The requested line length is rounded up to the next multiple of 8 bytes, and that rounded value is used in every derived word. Count1 therefore carries (rounded >> 3) − 1.
- R2: The line count is the largest n not above 6 for which n × rounded length ≤ FIFO size. It appears on lines_o from the cycle of the done pulse until the next sequence replaces it.
- R3: The descriptor table base is the control-area base + 64. Entry i (i = 0 … lines−1) is written at table base + 16·i with data FIFO start + rounded length · i. These are the first writes, in ascending i.
- R4: The command block follows next, word by word from the base upwards. Offset 0 holds the program start address, 4 the table base, 8 the value lines × 2, 12 the control-area base, and 16 the value 16.
- R5: Command-block words at offsets 20, 24, … 60 are written with zero, in ascending order, right after offset 16.
- R6: The last four writes go to register-group base +0, +4, +8 and +12. Their data are, in order: FIFO start, table base, (rounded >> 3) − 1, and lines × 2.
- R7: At most one write is outstanding. Once wr_valid_o rises, address and data stay unchanged until a cycle with wr_ack_i high. The next write can appear in the cycle after that.
- R8: If the rounded length is zero or exceeds the FIFO size, the block makes no write. Done and err_o then pulse together two cycles after start, and lines_o becomes 0.
- R9: done_o is a one-cycle pulse in the cycle after the last write is acknowledged. A good sequence consists of exactly lines + 20 writes.
- R10: busy_o is high from the cycle after start until the done pulse. A start pulse while busy is ignored, and the inputs are sampled only in the start cycle.
- R11: After reset busy_o, done_o, err_o and wr_valid_o are low and lines_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse, taken only while idle |
| cmd_base_i | input | AW | Command-block base address |
| ctrl_base_i | input | AW | Control-area base address |
| fifo_start_i | input | AW | FIFO start address in SRAM |
| fifo_size_i | input | SIZE_W | FIFO size in bytes |
| bpl_i | input | BPL_W | Requested bytes per line |
| prog_addr_i | input | AW | DMA program start address |
| reg_base_i | input | AW | Base of pointer/count register group |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end pulse |
| err_o | output | 1 | Geometry refused, valid with done_o |
| lines_o | output | LW | Line buffer count of the last sequence |
| wr_valid_o | output | 1 | Write request |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | AW | Write data |
| wr_ack_i | input | 1 | Write acknowledge |

## Verification
Suppose the step counter skips or repeats, or the latched length or line count is wrong. The address or data of the very next write request would then differ from the reference, in the first cycle that request is shown. If the rounding or the line capping is wrong, the descriptor data and the count words disagree as soon as the table is written. A state machine that enters or leaves the write phase at the wrong time shows up as a wr_valid_o or busy_o mismatch in the cycle after start or after the last acknowledge. Acknowledges are given without gaps, every other cycle and at irregular intervals, so a stalled write that drifts shows up during the stall itself.

// File: rtl/chan_desc_pkg.sv
package chan_desc_pkg;
  // Control area: instruction queue occupies the first bytes, table follows.
  localparam int unsigned QUEUE_BYTES = 64;
  localparam int unsigned DESC_STRIDE = 16;
  localparam int unsigned CMD_WORDS   = 16;
  localparam int unsigned REG_WORDS   = 4;
  localparam int unsigned FIXED_WRITES = CMD_WORDS + REG_WORDS;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CALC  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/chan_desc_lines.sv
module chan_desc_lines #(
  parameter int unsigned BPL_W     = 16,
  parameter int unsigned SIZE_W    = 24,
  parameter int unsigned MAX_LINES = 6,
  parameter int unsigned LW        = 3
) (
  input  logic [BPL_W-1:0]  bpl_req_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [BPL_W:0]    bpl_rnd_o,
  output logic [LW-1:0]     lines_o,
  output logic              bad_o
);
  localparam int unsigned KW = $clog2(MAX_LINES + 1);
  localparam int unsigned CW = BPL_W + 1 + KW + SIZE_W;

  function automatic logic [BPL_W:0] round_up8(input logic [BPL_W-1:0] b);
    return ({1'b0, b} + (BPL_W+1)'(7)) & ~((BPL_W+1)'(7));
  endfunction

  logic [MAX_LINES-1:0] fit;
  logic [LW-1:0]        cnt;

  assign bpl_rnd_o = round_up8(bpl_req_i);

  // One comparator per candidate count: k lines fit if k*len <= size.
  for (genvar k = 1; k <= MAX_LINES; k++) begin : g_fit
    logic [CW-1:0] span;
    assign span       = CW'(k) * CW'(bpl_rnd_o);
    assign fit[k-1]   = (span <= CW'(size_i));
  end

  always_comb begin
    cnt = '0;
    for (int k = 0; k < MAX_LINES; k++) begin
      if (fit[k]) cnt = cnt + LW'(1);
    end
  end

  assign bad_o   = (bpl_rnd_o == '0) || !fit[0];
  assign lines_o = bad_o ? '0 : cnt;
endmodule

// File: rtl/chan_desc_word.sv
module chan_desc_word
  import chan_desc_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned BPL_W = 16,
  parameter int unsigned LW    = 3,
  parameter int unsigned SW    = 5
) (
  input  logic [SW-1:0]  step_i,
  input  logic [LW-1:0]  lines_i,
  input  logic [AW-1:0]  cmd_base_i,
  input  logic [AW-1:0]  ctrl_base_i,
  input  logic [AW-1:0]  fifo_start_i,
  input  logic [AW-1:0]  reg_base_i,
  input  logic [AW-1:0]  prog_addr_i,
  input  logic [BPL_W:0] bpl_rnd_i,
  output logic [AW-1:0]  addr_o,
  output logic [AW-1:0]  data_o,
  output logic           last_o
);
  function automatic logic [AW-1:0] table_base(input logic [AW-1:0] ctrl);
    return ctrl + AW'(QUEUE_BYTES);
  endfunction

  function automatic logic [AW-1:0] ring_words(input logic [LW-1:0] n);
    return (AW'(n) * AW'(DESC_STRIDE)) >> 3;
  endfunction

  function automatic logic [AW-1:0] word_off(input logic [SW-1:0] idx);
    return AW'(idx) << 2;
  endfunction

  logic [SW-1:0] lines_ext;
  logic [SW-1:0] rel;
  logic [SW-1:0] reg_idx;
  logic [AW-1:0] tbl;

  assign lines_ext = SW'(lines_i);
  assign rel       = step_i - lines_ext;
  assign reg_idx   = rel - SW'(CMD_WORDS);
  assign tbl       = table_base(ctrl_base_i);
  assign last_o    = (step_i == lines_ext + SW'(FIXED_WRITES - 1));

  always_comb begin
    addr_o = '0;
    data_o = '0;
    if (step_i < lines_ext) begin
      addr_o = tbl + AW'(step_i) * AW'(DESC_STRIDE);
      data_o = fifo_start_i + AW'(bpl_rnd_i) * AW'(step_i);
    end else if (rel < SW'(CMD_WORDS)) begin
      addr_o = cmd_base_i + word_off(rel);
      unique case (int'(rel))
        0:       data_o = prog_addr_i;
        1:       data_o = tbl;
        2:       data_o = ring_words(lines_i);
        3:       data_o = ctrl_base_i;
        4:       data_o = AW'(QUEUE_BYTES >> 2);
        default: data_o = '0;
      endcase
    end else begin
      addr_o = reg_base_i + word_off(reg_idx);
      unique case (int'(reg_idx))
        0:       data_o = fifo_start_i;
        1:       data_o = tbl;
        2:       data_o = AW'(bpl_rnd_i >> 3) - AW'(1);
        default: data_o = ring_words(lines_i);
      endcase
    end
  end
endmodule

// File: rtl/chan_desc_seq.sv
module chan_desc_seq
  import chan_desc_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned SIZE_W    = 24,
  parameter int unsigned BPL_W     = 16,
  parameter int unsigned MAX_LINES = 6,
  parameter int unsigned LW        = $clog2(MAX_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     cmd_base_i,
  input  logic [AW-1:0]     ctrl_base_i,
  input  logic [AW-1:0]     fifo_start_i,
  input  logic [SIZE_W-1:0] fifo_size_i,
  input  logic [BPL_W-1:0]  bpl_i,
  input  logic [AW-1:0]     prog_addr_i,
  input  logic [AW-1:0]     reg_base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [LW-1:0]     lines_o,
  output logic              wr_valid_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [AW-1:0]     wr_data_o,
  input  logic              wr_ack_i
);
  localparam int unsigned SW = $clog2(MAX_LINES + FIXED_WRITES + 1);

  seq_state_e        state_q;
  logic [SW-1:0]     step_q;
  logic [LW-1:0]     lines_q;
  logic              done_q;
  logic              err_q;
  logic [AW-1:0]     cmd_q, ctrl_q, fifo_q, prog_q, reg_q;
  logic [SIZE_W-1:0] size_q;
  logic [BPL_W-1:0]  bpl_q;

  logic [BPL_W:0]    bpl_rnd_w;
  logic [LW-1:0]     calc_lines_w;
  logic              calc_bad_w;
  logic              last_w;

  // Named internal events, used by the FSM and observed by the checker.
  logic              calc_err_w;
  logic              wr_fire_w;

  chan_desc_lines #(
    .BPL_W(BPL_W), .SIZE_W(SIZE_W), .MAX_LINES(MAX_LINES), .LW(LW)
  ) u_lines (
    .bpl_req_i (bpl_q),
    .size_i    (size_q),
    .bpl_rnd_o (bpl_rnd_w),
    .lines_o   (calc_lines_w),
    .bad_o     (calc_bad_w)
  );

  chan_desc_word #(
    .AW(AW), .BPL_W(BPL_W), .LW(LW), .SW(SW)
  ) u_word (
    .step_i       (step_q),
    .lines_i      (lines_q),
    .cmd_base_i   (cmd_q),
    .ctrl_base_i  (ctrl_q),
    .fifo_start_i (fifo_q),
    .reg_base_i   (reg_q),
    .prog_addr_i  (prog_q),
    .bpl_rnd_i    (bpl_rnd_w),
    .addr_o       (wr_addr_o),
    .data_o       (wr_data_o),
    .last_o       (last_w)
  );

  assign wr_valid_o = (state_q == ST_WRITE);
  assign busy_o     = (state_q != ST_IDLE);
  assign calc_err_w = (state_q == ST_CALC) && calc_bad_w;
  assign wr_fire_w  = wr_valid_o && wr_ack_i;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign lines_o    = lines_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      lines_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cmd_q   <= '0;
      ctrl_q  <= '0;
      fifo_q  <= '0;
      prog_q  <= '0;
      reg_q   <= '0;
      size_q  <= '0;
      bpl_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cmd_q   <= cmd_base_i;
            ctrl_q  <= ctrl_base_i;
            fifo_q  <= fifo_start_i;
            prog_q  <= prog_addr_i;
            reg_q   <= reg_base_i;
            size_q  <= fifo_size_i;
            bpl_q   <= bpl_i;
            state_q <= ST_CALC;
          end
        end
        ST_CALC: begin
          lines_q <= calc_lines_w;
          step_q  <= '0;
          if (calc_err_w) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wr_fire_w) begin
            if (last_w) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              step_q <= step_q + SW'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chan_desc_seq_chk.sv
module chan_desc_seq_chk #(
  parameter int unsigned AW        = 32,
  parameter int unsigned MAX_LINES = 6,
  parameter int unsigned LW        = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ack,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] wr_data,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [LW-1:0] lines,
  input logic          calc_err,
  input logic          wr_fire
);
  localparam int unsigned CNT_W = $clog2(MAX_LINES + chan_desc_pkg::FIXED_WRITES + 2);

  logic [CNT_W-1:0] fire_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_cnt <= '0;
    else if (done) fire_cnt <= '0;
    else if (wr_fire) fire_cnt <= fire_cnt + CNT_W'(1);
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ack |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid);

  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    calc_err |=> done && err && !wr_valid && lines == '0);

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_lines_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lines <= LW'(MAX_LINES));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_write_total_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> fire_cnt == CNT_W'(lines) + CNT_W'(chan_desc_pkg::FIXED_WRITES));
endmodule

bind chan_desc_seq chan_desc_seq_chk #(
  .AW(AW), .MAX_LINES(MAX_LINES), .LW(LW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid_o),
  .wr_ack   (wr_ack_i),
  .wr_addr  (wr_addr_o),
  .wr_data  (wr_data_o),
  .busy     (busy_o),
  .done     (done_o),
  .err      (err_o),
  .lines    (lines_o),
  .calc_err (calc_err_w),
  .wr_fire  (wr_fire_w)
);

// File: tb/chan_desc_seq_bench.sv
`timescale 1ns/1ps
module chan_desc_seq_bench;
  localparam int unsigned AW = 32;
  localparam int unsigned SIZE_W = 24;
  localparam int unsigned BPL_W = 16;
  localparam int unsigned LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              start_d = 1'b0;
  logic [AW-1:0]     cmd_d = '0, ctrl_d = '0, fifo_d = '0, prog_d = '0, reg_d = '0;
  logic [SIZE_W-1:0] size_d = '0;
  logic [BPL_W-1:0]  bpl_d = '0;
  logic              ack_d = 1'b0;
  int                ack_mode = 0;

  logic              busy, done, err, wr_valid;
  logic [LW-1:0]     lines;
  logic [AW-1:0]     wr_addr, wr_data;

  chan_desc_seq u_chan_desc_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_d),
    .cmd_base_i(cmd_d), .ctrl_base_i(ctrl_d), .fifo_start_i(fifo_d),
    .fifo_size_i(size_d), .bpl_i(bpl_d), .prog_addr_i(prog_d), .reg_base_i(reg_d),
    .busy_o(busy), .done_o(done), .err_o(err), .lines_o(lines),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_ack_i(ack_d)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference model state: 0 idle, 1 computing, 2 writing, 3 done cycle.
  int          mphase = 0;
  bit          m_err = 1'b0;
  int          m_lines = 0;
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  string       q_tag[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input longint a, input longint d, input string t);
    q_addr.push_back(a[31:0]);
    q_data.push_back(d[31:0]);
    q_tag.push_back(t);
  endtask

  task automatic build_list();
    longint b, tbl, n;
    b = ((longint'(bpl_d) + 7) / 8) * 8;
    n = 0;
    while (n < 6 && (n + 1) * b <= longint'(size_d)) n++;
    m_err = (b == 0) || (b > longint'(size_d));
    m_lines = m_err ? 0 : int'(n);
    q_addr.delete(); q_data.delete(); q_tag.delete();
    if (m_err) return;
    tbl = longint'(ctrl_d) + 64;
    for (longint i = 0; i < n; i++) push(tbl + 16 * i, longint'(fifo_d) + b * i, "R3");
    push(cmd_d, prog_d, "R4");
    push(longint'(cmd_d) + 4, tbl, "R4");
    push(longint'(cmd_d) + 8, n * 2, "R4");
    push(longint'(cmd_d) + 12, ctrl_d, "R4");
    push(longint'(cmd_d) + 16, 16, "R4");
    for (int off = 20; off <= 60; off += 4) push(longint'(cmd_d) + off, 0, "R5");
    push(reg_d, fifo_d, "R6");
    push(longint'(reg_d) + 4, tbl, "R6");
    push(longint'(reg_d) + 8, b / 8 - 1, "R1");
    push(longint'(reg_d) + 12, n * 2, "R6");
  endtask

  // Model advances on the edge using only bench-driven values.
  always @(posedge clk) begin
    if (rst_n) begin
      case (mphase)
        1: mphase = m_err ? 3 : 2;
        2: if (ack_d) begin
             void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_tag.pop_front());
             if (q_addr.size() == 0) mphase = 3;
           end
        default: begin
          if (start_d) begin build_list(); mphase = 1; end
          else mphase = 0;
        end
      endcase
    end
  end

  int shown_lines = 0;
  bit shown_err = 1'b0;
  always @(posedge clk) if (rst_n && mphase == 1) begin shown_lines = m_lines; shown_err = m_err; end

  // Compare every cycle, then choose the next acknowledge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy == (mphase == 1 || mphase == 2), "R10", busy, (mphase == 1 || mphase == 2));
      check(done == (mphase == 3), "R9", done, (mphase == 3));
      check(err == (mphase == 3 && shown_err), "R8", err, (mphase == 3 && shown_err));
      check(wr_valid == (mphase == 2), "R7", wr_valid, (mphase == 2));
      if (mphase != 1) check(int'(lines) == shown_lines, "R2", lines, shown_lines);
      if (mphase == 2 && q_addr.size() > 0) begin
        check(wr_addr == q_addr[0], q_tag[0], wr_addr, q_addr[0]);
        check(wr_data == q_data[0], q_tag[0], wr_data, q_data[0]);
      end
      case (ack_mode)
        0: ack_d = 1'b1;
        1: ack_d = ~ack_d;
        default: ack_d = ($urandom % 3) != 0;
      endcase
    end
  end

  task automatic launch(input logic [31:0] c, input logic [31:0] k, input logic [31:0] f,
                        input logic [23:0] s, input logic [15:0] b, input logic [31:0] p,
                        input logic [31:0] r);
    @(negedge clk);
    cmd_d = c; ctrl_d = k; fifo_d = f; size_d = s; bpl_d = b; prog_d = p; reg_d = r;
    start_d = 1'b1;
    @(negedge clk);
    start_d = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (mphase != 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_case(input logic [23:0] s, input logic [15:0] b, input int exp_lines,
                          input bit exp_err);
    bit saw_done = 1'b0, saw_err = 1'b0;
    launch(32'h0018_0040, 32'h0018_0400, 32'h0018_0c00, s, b, 32'h0000_1000, 32'h0020_0000);
    do begin
      @(negedge clk);
      if (done) begin saw_done = 1'b1; saw_err = err; end
    end while (mphase != 0);
    check(saw_done, "R9", saw_done, 1);
    check(saw_err == exp_err, "R8", saw_err, exp_err);
    check(int'(lines) == exp_lines, "R2", lines, exp_lines);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !wr_valid && lines == '0, "R11",
          {busy, done, err, wr_valid, 1'b0, lines}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    ack_mode = 0; run_case(24'h2800, 16'd2880, 3, 1'b0);
    ack_mode = 1; run_case(24'h0800, 16'd128, 6, 1'b0);
    ack_mode = 2; run_case(24'd300, 16'd100, 2, 1'b0);
    ack_mode = 2; run_case(24'd64, 16'd64, 1, 1'b0);
    ack_mode = 0; run_case(24'd100, 16'd200, 0, 1'b1);
    ack_mode = 1; run_case(24'h1000, 16'd0, 0, 1'b1);
    ack_mode = 2; run_case(24'h20000, 16'hffff, 2, 1'b0);

    // R10: a second start while busy with different geometry is ignored.
    ack_mode = 1;
    launch(32'h0018_0080, 32'h0018_04a0, 32'h0018_3400, 24'h0800, 16'd128,
           32'h0000_2000, 32'h0020_0100);
    repeat (3) @(negedge clk);
    launch(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 24'h0010, 16'd8,
           32'h0000_0000, 32'h0000_0000);
    wait_idle();
    check(int'(lines) == 6, "R10", lines, 6);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule